// File: doc/BRIEF.md
# Saturating 64-by-32 Divide Unit

This block performs one integer division at a time for a 32-bit processor datapath. The dividend is 64 bits wide. Its upper word comes from a separate high-word register and its lower word from the first operand. The divisor is the second operand. A single mode input selects signed or unsigned arithmetic. A quotient that does not fit in 32 bits is clamped to the nearest representable limit, and an overflow bit is raised. A zero divisor does not produce a quotient. It raises a trap indication instead.

The datapath issues a one-cycle start pulse with the operands, the mode and a set-flags request. It then waits for the result. The result is held on a valid/ready handshake until the consumer takes it. When the set-flags request was given, the clamped quotient and the overflow bit are also copied into a pair of condition-code source registers. These registers are visible at the ports and keep their value otherwise.

Internally the unit is a radix-2 restoring divider that works on magnitudes. It runs a fixed number of iterations, one per dividend bit, and applies sign correction and clamping in a final step.

Top module: `sat_divider`

## Requirements
- R1: The dividend is `{hi_word, op_a}` and the divisor is `op_b`. In unsigned mode (`signed_mode`=0) the quotient is the truncated unsigned quotient whenever it is at most 0xFFFFFFFF, with `ovf`=0.
- R2: When `op_b` is zero, the result has `div_zero`=1, `ovf`=0 and `quotient`=0. It is valid one clock after the start is taken, and the flag registers do not change.
- R3: In unsigned mode a quotient above 0xFFFFFFFF is delivered as 0xFFFFFFFF with `ovf`=1.
- R4: In signed mode (`signed_mode`=1) a dividend of 0x8000000000000000 divided by 0xFFFFFFFF (-1) gives 0x7FFFFFFF with `ovf`=1.
- R5: In signed mode both operands are two's complement and the quotient truncates toward zero. A quotient above 2^31-1 gives 0x7FFFFFFF with `ovf`=1. A quotient below -2^31 gives 0x80000000 with `ovf`=1.
- R6: When `set_flags` was high with the accepted start and no trap occurs, `flag_quot` and `flag_ovf` take the delivered quotient and overflow in the same cycle that `out_valid` rises. Otherwise they keep their value.
- R7: `busy` is high from the cycle after a start is taken until the result is consumed. A `start` while `busy` is high is ignored and does not change the pending result.
- R8: While `out_valid` is high and `out_ready` is low, `quotient`, `ovf`, `div_zero` and `out_valid` hold. `out_valid` and `busy` drop one clock after `out_ready` is seen high.
- R9: For a nonzero divisor, `out_valid` rises 65 clocks after the edge that takes the start. That is 64 iterations plus one finish cycle.
- R10: A synchronous active-high `rst` returns the unit to idle with `busy`=0, `out_valid`=0, and all result and flag outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| signed_mode | input | 1 | 1 = signed division, 0 = unsigned |
| set_flags | input | 1 | Copy result into flag registers |
| hi_word | input | 32 | Upper half of the dividend |
| op_a | input | 32 | Lower half of the dividend |
| op_b | input | 32 | Divisor |
| busy | output | 1 | Operation in progress or result pending |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| quotient | output | 32 | Clamped quotient |
| ovf | output | 1 | Quotient was clamped |
| div_zero | output | 1 | Divide-by-zero trap |
| flag_quot | output | 32 | Latched quotient for condition codes |
| flag_ovf | output | 1 | Latched overflow for condition codes |

## Verification
A zero-divisor result is due one clock after the start edge, and every other result is due 65 clocks after it. The bench drives start half a period before an edge and counts edges at falling edges until `out_valid` appears. It compares that count with the expected latency rather than waiting without a bound. Outputs and flag registers are sampled at falling edges right after `out_valid` rises. They are sampled again after a random number of stalled cycles, and the bench asserts `out_ready` only after those checks are done.

// File: rtl/sat_divider.sv
module sat_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         signed_mode,
  input  logic         set_flags,
  input  logic [W-1:0] hi_word,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] quotient,
  output logic         ovf,
  output logic         div_zero,
  output logic [W-1:0] flag_quot,
  output logic         flag_ovf
);
  localparam int DW   = 2 * W;
  localparam int ITER = DW;
  localparam int CW   = $clog2(ITER + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_DONE} state_t;
  state_t state;

  logic [DW-1:0] work;
  logic [W-1:0]  rem, dvs;
  logic [CW-1:0] cnt;
  logic          neg, sgn, sf_l;

  wire [DW-1:0] dvd     = {hi_word, op_a};
  wire          dvd_neg = signed_mode & hi_word[W-1];
  wire          dvs_neg = signed_mode & op_b[W-1];
  wire          take    = start && state == S_IDLE;

  wire [W:0]    rem_sh = {rem, work[DW-1]};
  wire          ge     = rem_sh >= {1'b0, dvs};
  wire [W-1:0]  rem_nx = ge ? rem_sh[W-1:0] - dvs : rem_sh[W-1:0];

  wire          hi_nz  = |work[DW-1:W];
  wire [W-1:0]  lo     = work[W-1:0];
  logic [W-1:0] fin_q;
  logic         fin_o;

  always_comb begin
    if (!sgn) begin
      fin_o = hi_nz;
      fin_q = fin_o ? {W{1'b1}} : lo;
    end else if (!neg) begin
      fin_o = hi_nz | lo[W-1];
      fin_q = fin_o ? {1'b0, {(W-1){1'b1}}} : lo;
    end else begin
      fin_o = hi_nz | (lo[W-1] & |lo[W-2:0]);
      fin_q = fin_o ? {1'b1, {(W-1){1'b0}}} : -lo;
    end
  end

  assign busy      = state != S_IDLE;
  assign out_valid = state == S_DONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      work      <= '0;
      rem       <= '0;
      dvs       <= '0;
      cnt       <= '0;
      neg       <= 1'b0;
      sgn       <= 1'b0;
      sf_l      <= 1'b0;
      quotient  <= '0;
      ovf       <= 1'b0;
      div_zero  <= 1'b0;
      flag_quot <= '0;
      flag_ovf  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          if (op_b == '0) begin
            quotient <= '0;
            ovf      <= 1'b0;
            div_zero <= 1'b1;
            state    <= S_DONE;
          end else begin
            work     <= dvd_neg ? -dvd : dvd;
            dvs      <= dvs_neg ? -op_b : op_b;
            rem      <= '0;
            cnt      <= '0;
            neg      <= dvd_neg ^ dvs_neg;
            sgn      <= signed_mode;
            sf_l     <= set_flags;
            div_zero <= 1'b0;
            state    <= S_RUN;
          end
        end
        S_RUN: begin
          rem  <= rem_nx;
          work <= {work[DW-2:0], ge};
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(ITER - 1)) state <= S_FIN;
        end
        S_FIN: begin
          quotient <= fin_q;
          ovf      <= fin_o;
          if (sf_l) begin
            flag_quot <= fin_q;
            flag_ovf  <= fin_o;
          end
          state <= S_DONE;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sat_divider_chk.sv
module sat_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] quotient,
  input logic         ovf,
  input logic         div_zero,
  input logic [W-1:0] flag_quot,
  input logic         flag_ovf
);
  localparam int LAT = 2 * W + 1;
  int unsigned since;

  always_ff @(posedge clk) begin
    if (rst) since <= 0;
    else if (start && !busy) since <= 0;
    else if (busy && !out_valid) since <= since + 1;
  end

  AST_TRAP_CLEAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && div_zero |-> !ovf && quotient == '0); // R2
  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (rst)
    out_valid && ovf |-> quotient == {W{1'b1}} || quotient == {1'b0, {(W-1){1'b1}}}
                        || quotient == {1'b1, {(W-1){1'b0}}}); // R3
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(flag_quot) && $stable(flag_ovf)); // R6
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(quotient) && $stable(ovf)
                                && $stable(div_zero)); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid && !busy); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> div_zero || since == LAT); // R9
endmodule

bind sat_divider sat_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .out_valid(out_valid),
  .out_ready(out_ready), .quotient(quotient), .ovf(ovf), .div_zero(div_zero),
  .flag_quot(flag_quot), .flag_ovf(flag_ovf)
);

// File: tb/test_sat_divider.sv
module test_sat_divider;
  localparam int CLK_P = 10;
  localparam int LAT   = 65;

  logic clk = 0, rst = 1, start = 0, signed_mode = 0, set_flags = 0, out_ready = 0;
  logic [31:0] hi_word = 0, op_a = 0, op_b = 0;
  logic busy, out_valid, ovf, div_zero, flag_ovf;
  logic [31:0] quotient, flag_quot;
  int errors = 0, checks = 0;
  logic [31:0] e_fq = 0;
  logic        e_fo = 0;

  always #(CLK_P/2) clk = ~clk;

  sat_divider i_sat_divider (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode), .set_flags(set_flags),
    .hi_word(hi_word), .op_a(op_a), .op_b(op_b), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .quotient(quotient), .ovf(ovf), .div_zero(div_zero),
    .flag_quot(flag_quot), .flag_ovf(flag_ovf)
  );

  function automatic logic [33:0] ref_div(logic [31:0] h, logic [31:0] a, logic [31:0] b, logic sm);
    logic [63:0] un, uq;
    longint sn, sd, sq;
    if (b == 0) return {1'b1, 1'b0, 32'h0};
    if (!sm) begin
      un = {h, a};
      uq = un / {32'h0, b};
      if (uq > 64'hFFFF_FFFF) return {1'b0, 1'b1, 32'hFFFF_FFFF};
      return {1'b0, 1'b0, uq[31:0]};
    end
    sn = signed'({h, a});
    sd = longint'(signed'(b));
    if (sn == 64'sh8000_0000_0000_0000 && sd == -1) return {1'b0, 1'b1, 32'h7FFF_FFFF};
    sq = sn / sd;
    if (sq > 64'sd2147483647)  return {1'b0, 1'b1, 32'h7FFF_FFFF};
    if (sq < -64'sd2147483648) return {1'b0, 1'b1, 32'h8000_0000};
    return {1'b0, 1'b0, sq[31:0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] h, logic [31:0] a, logic [31:0] b, logic sm, logic sf,
                     bit poke, string req);
    logic [33:0] e;
    int n;
    int stall;
    e = ref_div(h, a, b, sm);
    @(negedge clk);
    start = 1; hi_word = h; op_a = a; op_b = b; signed_mode = sm; set_flags = sf;
    @(negedge clk);
    start = 0;
    n = 1;
    chk("R7 busy after start", 64'(busy), 64'd1);
    while (!out_valid && n < 200) begin
      if (poke && n == 10) begin
        start = 1; hi_word = ~h; op_a = ~a; op_b = b ^ 32'h5; signed_mode = ~sm; set_flags = 1;
      end else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    chk({req, " R9 latency"}, 64'(n), 64'(e[33] ? 1 : LAT + 1));
    chk({req, " result"}, {30'h0, div_zero, ovf, quotient}, {30'h0, e});
    if (sf && !e[33]) begin e_fq = e[31:0]; e_fo = e[32]; end
    chk({req, " R6 flags"}, {31'h0, flag_ovf, flag_quot}, {31'h0, e_fo, e_fq});
    stall = $urandom_range(0, 3);
    repeat (stall) @(negedge clk);
    chk({req, " R8 hold"}, {29'h0, out_valid, div_zero, ovf, quotient}, {29'h0, 1'b1, e});
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk({req, " R8 release"}, {out_valid, busy}, 2'b00);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 reset", {31'h0, busy, out_valid, ovf, div_zero, flag_ovf, quotient, flag_quot[26:0]}, 64'h0);
    run(32'h0, 32'd100, 32'd7, 0, 1, 0, "R1 unsigned");
    run(32'h1, 32'h0, 32'h2, 0, 1, 0, "R1 hi word");
    run(32'h5, 32'h0, 32'h3, 0, 1, 0, "R3 unsigned sat");
    run(32'h1234, 32'h1, 32'h0, 0, 1, 0, "R2 zero divisor");
    run(32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 1, 1, 0, "R4 min by minus one");
    run(32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 1, 1, 0, "R5 neg trunc");
    run(32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0, "R5 exact neg limit");
    run(32'h0, 32'h8000_0000, 32'h1, 1, 1, 0, "R5 pos sat");
    run(32'hFFFF_FFFE, 32'h0, 32'h1, 1, 1, 0, "R5 neg sat");
    run(32'h0, 32'd50, 32'd5, 0, 0, 0, "R6 no flag update");
    run(32'h0, 32'd1000, 32'd10, 0, 1, 1, "R7 start ignored");
    for (int i = 0; i < 250; i++) begin
      logic [31:0] h, a, b;
      h = $urandom; a = $urandom; b = $urandom;
      case ($urandom_range(0, 3))
        0: h = h >> $urandom_range(0, 31);
        1: b = b >> $urandom_range(0, 31);
        2: h = {32{h[0]}};
        default: ;
      endcase
      run(h, a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R1 R5 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule